// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed SPI master that issues one serial-flash command per launch. Software fills in a command byte, an optional 24-bit flash address, a byte count and, for outbound transfers, up to four payload bytes. It then sets the launch bit in the control register. The engine drops chip select and shifts out the command byte, then the address, then either the payload or dummy clocks while it collects inbound bytes. It then releases chip select, waits out a recovery gap and clears the busy bit that software polls.

The byte count is read differently in the two directions. For an outbound command it counts only the payload bytes that follow the command byte and any address. For an inbound command it counts the bytes to receive. Payload bytes and received bytes are packed with byte 0 in bits [7:0]. The address leaves most significant byte first. The serial clock runs in mode 0 at the system clock divided by an even parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the control, address, payload and receive registers read 0, chip select is high, SCK is low and busy reads 0.
- R2: Byte offsets are 0x0 control, 0x4 address, 0x8 payload, 0xC receive. The control register reads back busy in bit 0, address enable in bit 1, inbound direction in bit 2, the count in bits [6:4] and the command byte in bits [15:8], with all other bits 0. The address register keeps bits [23:0] and reads 0 above them.
- R3: A control write with bit 0 set launches a command. Bit 0 then reads 1 from the next cycle until the command and its recovery gap are over.
- R4: A command with count 0 and the address disabled produces exactly 8 SCK pulses that carry the command byte.
- R5: With bit 1 set, the 24 address bits follow the command byte, bit 23 first.
- R6: An outbound command sends count payload bytes after the header, starting with payload bits [7:0], each byte MSB first.
- R7: An inbound command receives count bytes after the header, MSB first. Received byte i lands in receive bits [8i+7:8i], and receive bytes beyond the count keep their prior value.
- R8: A count above 4 moves 4 data bytes.
- R9: SCK idles low and has a period of CLK_DIV system cycles. MOSI changes only after a falling SCK edge.
- R10: Chip select goes low CLK_DIV/2 cycles before the first rising SCK edge and returns high CLK_DIV/2 cycles after the last falling edge.
- R11: Chip select stays high for CS_GAP cycles (at least 2) before busy clears, so no new command can begin sooner.
- R12: While busy, host writes to any register, including a new launch, have no effect.
- R13: When idle, the host may write any value into the receive register, for example 0xFFFFFFFF as a debug preset, and it reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 4 | Register byte offset |
| busWdata | input | 32 | Register write data |
| busRdata | output | 32 | Register read data for busAddr |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to flash |
| spiMiso | input | 1 | Serial data from flash |

## Verification
The bench builds the engine with CLK_DIV = 4 and CS_GAP = 3. A half period of two cycles lets the lead, tail and period measurements tell a one-cycle slip from a correct edge. A gap of three, rather than the minimum of two, shows whether the recovery wait follows the parameter or a hard-wired constant. The inbound commands use a flash model whose response word differs in every byte, so a swapped byte lane or a reversed bit order produces a visible mismatch.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int REG_W = 32;
  localparam int CNT_W = 3;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_WDATA = 2'd2;
  localparam logic [1:0] SEL_RDATA = 2'd3;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic sckLevel;
    logic csActive;
  } seqStrobe_t;

endpackage

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int ADDR_BITS  = 24,
  parameter int BIT_W      = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic [3:0]       busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic             busy,
  input  seqStrobe_t       stb,
  input  logic             spiMiso,
  output logic             spiMosi,
  output logic             launch,
  output logic [BIT_W-1:0] numBits
);

  localparam int TX_W   = 8 + ADDR_BITS + 8 * DATA_BYTES;
  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int IDX_W  = $clog2(DATA_W);

  logic                 ctrlAddrEn, ctrlRead;
  logic [CNT_W-1:0]     ctrlCnt;
  logic [7:0]           ctrlOp;
  logic [ADDR_BITS-1:0] addrReg;
  logic [REG_W-1:0]     wdataReg, rdataReg;
  logic [TX_W-1:0]      txShift, txImage;
  logic [BIT_W-1:0]     rxPos, hdrBits, dataBit;
  logic [CNT_W-1:0]     dataBytes;
  logic [1:0]           regSel;
  logic                 aligned, hostWr;

  assign regSel  = busAddr[3:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign hostWr  = busWe && aligned && !busy;
  assign launch  = hostWr && (regSel == SEL_CTRL) && busWdata[0];

  assign dataBytes = (ctrlCnt > CNT_W'(DATA_BYTES)) ? CNT_W'(DATA_BYTES) : ctrlCnt;
  assign hdrBits   = ctrlAddrEn ? BIT_W'(8 + ADDR_BITS) : BIT_W'(8);
  assign numBits   = hdrBits + (BIT_W'(dataBytes) << 3);
  assign dataBit   = rxPos - hdrBits;

  always_comb begin
    int dataTop;
    txImage = '0;
    txImage[TX_W-1 -: 8] = ctrlOp;
    if (ctrlAddrEn) txImage[TX_W-9 -: ADDR_BITS] = addrReg;
    dataTop = TX_W - 1 - int'(hdrBits);
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (!ctrlRead && (i < int'(dataBytes)))
        txImage[dataTop - 8*i -: 8] = wdataReg[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlAddrEn <= 1'b0;
      ctrlRead   <= 1'b0;
      ctrlCnt    <= '0;
      ctrlOp     <= '0;
      addrReg    <= '0;
      wdataReg   <= '0;
      rdataReg   <= '0;
    end else if (hostWr) begin
      unique case (regSel)
        SEL_CTRL: begin
          ctrlAddrEn <= busWdata[1];
          ctrlRead   <= busWdata[2];
          ctrlCnt    <= busWdata[6:4];
          ctrlOp     <= busWdata[15:8];
        end
        SEL_ADDR:  addrReg  <= busWdata[ADDR_BITS-1:0];
        SEL_WDATA: wdataReg <= busWdata;
        default:   rdataReg <= busWdata;
      endcase
    end else if (stb.sample && ctrlRead && (rxPos >= hdrBits) &&
                 (dataBit < BIT_W'(DATA_W))) begin
      rdataReg[{dataBit[IDX_W-1:3], ~dataBit[2:0]}] <= spiMiso;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxPos   <= '0;
    end else begin
      if (stb.load)       txShift <= txImage;
      else if (stb.shift) txShift <= {txShift[TX_W-2:0], 1'b0};
      if (stb.load)        rxPos <= '0;
      else if (stb.sample) rxPos <= rxPos + 1'b1;
    end
  end

  assign spiMosi = txShift[TX_W-1];

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      unique case (regSel)
        SEL_CTRL:  busRdata = {16'h0, ctrlOp, 1'b0, ctrlCnt, 1'b0, ctrlRead, ctrlAddrEn, busy};
        SEL_ADDR:  busRdata = REG_W'(addrReg);
        SEL_WDATA: busRdata = wdataReg;
        default:   busRdata = rdataReg;
      endcase
    end
  end

  // R9
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sckLevel && $past(stb.sckLevel)) |-> $stable(spiMosi));

  // R12
  locked_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(addrReg) && $stable(wdataReg) && $stable(ctrlOp)));

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 2,
  parameter int BIT_W   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             launch,
  input  logic [BIT_W-1:0] numBits,
  output logic             busy,
  output seqStrobe_t       stb,
  output logic             spiSck,
  output logic             spiCsN
);

  localparam int HALF    = CLK_DIV / 2;
  localparam int TIM_MAX = (HALF > CS_GAP) ? HALF : CS_GAP;
  localparam int TIM_W   = $clog2(TIM_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SETUP, ST_HIGH, ST_LOW, ST_TAIL, ST_GAP
  } seqState_t;

  seqState_t        state;
  logic [TIM_W-1:0] timer;
  logic [BIT_W-1:0] bitsLeft;
  logic             phaseEnd, lastBit;

  assign phaseEnd = (state == ST_GAP) ? (timer == TIM_W'(CS_GAP - 1))
                                      : (timer == TIM_W'(HALF - 1));
  assign lastBit  = (bitsLeft == BIT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      bitsLeft <= '0;
    end else begin
      timer <= (phaseEnd || state == ST_IDLE || state == ST_LOAD) ? '0 : timer + 1'b1;
      unique case (state)
        ST_IDLE: if (launch) state <= ST_LOAD;
        ST_LOAD: begin
          bitsLeft <= numBits;
          state    <= ST_SETUP;
        end
        ST_SETUP, ST_LOW: if (phaseEnd) state <= ST_HIGH;
        ST_HIGH: if (phaseEnd) begin
          if (lastBit) state <= ST_TAIL;
          else begin
            state    <= ST_LOW;
            bitsLeft <= bitsLeft - 1'b1;
          end
        end
        ST_TAIL: if (phaseEnd) state <= ST_GAP;
        ST_GAP:  if (phaseEnd) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load     = (state == ST_LOAD);
    stb.sample   = (state == ST_SETUP || state == ST_LOW) && phaseEnd;
    stb.shift    = (state == ST_HIGH) && phaseEnd && !lastBit;
    stb.sckLevel = (state == ST_HIGH);
    stb.csActive = (state == ST_SETUP) || (state == ST_HIGH) ||
                   (state == ST_LOW) || (state == ST_TAIL);
  end

  assign busy   = (state != ST_IDLE);
  assign spiSck = stb.sckLevel;
  assign spiCsN = !stb.csActive;

  // R3
  launch_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> busy);

  // R11
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(spiCsN, 1) && $past(spiCsN, 2)));

  // R9
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $changed(spiSck) |-> !spiCsN);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int CS_GAP     = 2,
  parameter int DATA_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        spiCsN,
  output logic        spiSck,
  output logic        spiMosi,
  input  logic        spiMiso
);

  localparam int ADDR_BITS = 24;
  localparam int BIT_W     = $clog2(8 + ADDR_BITS + 8 * DATA_BYTES + 1);

  seqStrobe_t       stb;
  logic             busy, launch;
  logic [BIT_W-1:0] numBits;

  spi_cmd_ctrl #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .BIT_W(BIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .launch(launch), .numBits(numBits),
    .busy(busy), .stb(stb), .spiSck(spiSck), .spiCsN(spiCsN)
  );

  spi_cmd_dp #(.DATA_BYTES(DATA_BYTES), .ADDR_BITS(ADDR_BITS), .BIT_W(BIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busy(busy), .stb(stb),
    .spiMiso(spiMiso), .spiMosi(spiMosi), .launch(launch), .numBits(numBits)
  );

endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;

  localparam int CLK_DIV = 4;
  localparam int CS_GAP  = 3;
  localparam int HALF    = CLK_DIV / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        spiCsN, spiSck, spiMosi;
  logic        spiMiso = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  int riseCnt, fallCyc, leadCyc, lastRise, lastFall, tailCyc, csRiseCyc, idleCyc;
  int minPer, maxPer;
  logic [63:0] mosiCap, respWord, respShift;
  logic prevCs = 1'b1, prevSck = 1'b0;

  spi_cmd_engine #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .DATA_BYTES(4)) u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .spiCsN(spiCsN),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // flash model and line monitor, all sampled away from the active edge
  always @(negedge clk) begin
    if (prevCs && !spiCsN) begin
      fallCyc = cyc; riseCnt = 0; mosiCap = '0;
      minPer = 1000; maxPer = 0;
      spiMiso = respWord[63]; respShift = respWord << 1;
    end
    if (!prevSck && spiSck) begin
      riseCnt++;
      mosiCap = {mosiCap[62:0], spiMosi};
      if (riseCnt == 1) leadCyc = cyc - fallCyc;
      else begin
        if (cyc - lastRise < minPer) minPer = cyc - lastRise;
        if (cyc - lastRise > maxPer) maxPer = cyc - lastRise;
      end
      lastRise = cyc;
    end
    if (prevSck && !spiSck) begin
      lastFall = cyc;
      spiMiso = respShift[63]; respShift = respShift << 1;
    end
    if (!prevCs && spiCsN) begin
      tailCyc = cyc - lastFall; csRiseCyc = cyc;
    end
    prevCs = spiCsN; prevSck = spiSck;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic regRd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int n = 0; n < 5000; n++) begin
      regRd(4'h0, v);
      if (!v[0]) begin idleCyc = cyc; return; end
    end
    chk("R3 busy never cleared", 1, 0);
  endtask

  task automatic runCmd(input logic [31:0] ctrlWord);
    regWr(4'h0, ctrlWord);
    waitIdle();
  endtask

  function automatic logic [31:0] expRead(input logic [63:0] resp, input int hdr,
                                          input int cnt, input logic [31:0] prior);
    logic [63:0] s = resp << hdr;
    logic [31:0] r = prior;
    for (int i = 0; i < cnt; i++) r[8*i +: 8] = s[63 - 8*i -: 8];
    return r;
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      regRd(4'(4 * k), v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 cs idle", spiCsN, 1);
    chk("R1 sck idle", spiSck, 0);
  endtask

  task automatic t_opOnly();
    respWord = '0;
    runCmd(32'h0000_0601);
    chk("R4 pulse count", riseCnt, 8);
    chk("R4 opcode bits", mosiCap[7:0], 8'h06);
    chk("R10 cs lead", leadCyc, HALF);
    chk("R10 cs tail", tailCyc, HALF);
    chk("R9 min period", minPer, CLK_DIV);
    chk("R9 max period", maxPer, CLK_DIV);
    chk("R11 gap before idle", idleCyc - csRiseCyc, CS_GAP);
    chk("R9 sck idle after", spiSck, 0);
  endtask

  task automatic t_writeAddr();
    logic [31:0] v;
    regWr(4'h4, 32'hAB12_3456);
    regRd(4'h4, v);
    chk("R2 address width", v, 32'h0012_3456);
    regWr(4'h8, 32'h4433_2211);
    runCmd(32'h0000_0223);
    chk("R5 R6 pulse count", riseCnt, 48);
    chk("R5 R6 frame bits", mosiCap[47:0], 48'h02_123456_11_22);
    regRd(4'h0, v);
    chk("R2 control readback", v, 32'h0000_0222);
  endtask

  task automatic t_write4();
    logic [31:0] v;
    regWr(4'h8, 32'hDDCC_BBAA);
    runCmd(32'h0000_4241);
    chk("R6 pulse count", riseCnt, 40);
    chk("R6 payload order", mosiCap[39:0], 40'h42_AA_BB_CC_DD);
    regRd(4'h8, v);
    chk("R2 payload readback", v, 32'hDDCC_BBAA);
  endtask

  task automatic t_clamp();
    runCmd(32'h0000_4271);
    chk("R8 clamped pulses", riseCnt, 40);
    chk("R8 clamped bits", mosiCap[39:0], 40'h42_AA_BB_CC_DD);
  endtask

  task automatic t_read2();
    logic [31:0] v;
    regWr(4'hC, 32'hFFFF_FFFF);
    regRd(4'hC, v);
    chk("R13 preset readback", v, 32'hFFFF_FFFF);
    respWord = 64'hA5C3_0F96_1234_5678;
    runCmd(32'h0000_9F25);
    chk("R7 pulse count", riseCnt, 24);
    regRd(4'hC, v);
    chk("R7 two bytes, rest kept", v, expRead(respWord, 8, 2, 32'hFFFF_FFFF));
  endtask

  task automatic t_read4Addr();
    logic [31:0] v;
    regWr(4'h4, 32'h0000_0100);
    respWord = 64'h1122_3344_8765_4321;
    runCmd(32'h0000_0347);
    chk("R5 R7 pulse count", riseCnt, 64);
    chk("R5 header on MOSI", mosiCap[63:32], 32'h0300_0100);
    regRd(4'hC, v);
    chk("R7 four bytes", v, expRead(respWord, 32, 4, 32'hFFFF_0F96));
  endtask

  task automatic t_busyIgnore();
    logic [31:0] v, expR;
    regWr(4'h4, 32'h0055_AA00);
    regWr(4'h8, 32'h0BAD_F00D);
    respWord = 64'hF0E1_D2C3_B4A5_9687;
    regWr(4'h0, 32'h0000_0B47);
    regRd(4'h0, v);
    chk("R3 busy reads 1", v[0], 1);
    regWr(4'h4, 32'h00FF_FFFF);
    regWr(4'h8, 32'h0000_0000);
    regWr(4'hC, 32'h0000_0000);
    regWr(4'h0, 32'h0000_0601);
    waitIdle();
    expR = expRead(respWord, 32, 4, 32'h0);
    regRd(4'h4, v);
    chk("R12 address kept", v, 32'h0055_AA00);
    regRd(4'h8, v);
    chk("R12 payload kept", v, 32'h0BAD_F00D);
    regRd(4'hC, v);
    chk("R12 receive not overwritten", v, expR);
    regRd(4'h0, v);
    chk("R12 control kept", v, 32'h0000_0B46);
    chk("R12 one frame only", riseCnt, 64);
    repeat (20) @(negedge clk);
    chk("R12 no relaunch", spiCsN, 1);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    respWord = '0; respShift = '0; riseCnt = 0; mosiCap = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_opOnly();
    t_writeAddr();
    t_write4();
    t_clamp();
    t_read2();
    t_read4Addr();
    t_busyIgnore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule